// File: doc/BRIEF.md
# Measurement-Synchronized Cell Balance Gate

This block sits between the cell-balancing request register of a battery-stack monitor and the drivers of its twelve discharge switches. Outside a cell-voltage conversion it passes each request bit straight to its switch. During a conversion it can suppress balancing near the cells being measured, so that discharge current does not disturb those readings. Only the switches close to the active measurement are turned off. The rest keep balancing.

A conversion walks through twelve periods, numbered by the sequencer. Periods 0 to 5 measure the cell pairs (1,7), (2,8), (3,9), (4,10), (5,11) and (6,12) in that order. Periods 6 to 11 calibrate the same pairs in the same order. The conversion command carries a permit bit. If it is set, balancing runs undisturbed. If it is clear, a three-wide window that follows the active pair forces off the switches whose cell, or a neighbouring cell, is under measurement. The result is registered before it leaves the block.

Top module: `cell_bal_gate`

## Requirements
- R1: While `rst_n` is low, `dis_drive_o` is all zeros (every switch off), whatever the inputs.
- R2: When `busy_i` was 0 at a clock edge, `dis_drive_o` after that edge equals `dis_req_i` as sampled at that edge.
- R3: If the permit bit sampled at the start of a conversion is 1, `dis_drive_o` equals the request for the whole conversion, in every period.
- R4: If the sampled permit bit is 0, output bit n-1 (cell n, n = 1..12) is forced off when the active pair index p is one of (k-1) mod 6, k or (k+1) mod 6, where k = (n-1) mod 6. Otherwise it follows its request bit. For period values 0..5, p equals the period.
- R5: Period values 6..11 are calibration periods and apply the same mask as period value minus 6.
- R6: Cells n and n+6 (bits n-1 and n+5) always receive the same gating decision.
- R7: With all requests set and permit 0, exactly 6 of the 12 outputs are on in every period 0..11. Each cell is forced off in exactly 3 of the 6 pair positions.
- R8: The permit bit is sampled in the first cycle in which `busy_i` is 1. Changes to `permit_i` while `busy_i` stays 1 have no effect. It is sampled again at the next conversion start.
- R9: The output is registered. A change of `period_i` appears on `dis_drive_o` one clock edge after it is sampled, and not before.
- R10: Period values 12..15 apply no mask, so the output equals the request.
- R11: An output is never on unless its request bit was set at the edge that produced it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously |
| dis_req_i | input | 12 | Requested discharge state, bit n-1 for cell n |
| permit_i | input | 1 | Discharge-permit bit of the conversion command |
| busy_i | input | 1 | A cell-voltage conversion is in progress |
| period_i | input | 4 | Active conversion period, 0..11 |
| dis_drive_o | output | 12 | Registered drive for the discharge switches |

## Verification
The bench targets the wrap-around of the three-wide window at pair positions 0 and 5. A decoder without modular wrap would leave cells 1, 6, 7 and 12 on at the ends of the sequence. It also checks that the calibration periods repeat the measurement masks. A decoder that only recognised values 0..5 would stop gating during calibration. The permit bit is flipped in mid-conversion in both directions. A block that read it live rather than latching it at the busy edge would gate or ungate in the middle of a run. Finally, the output is sampled before and after the clock edge that follows a period change. A combinational path, or an extra pipeline stage, would show up as a mask that arrives a cycle early or a cycle late.

// File: rtl/cell_bal_gate_pkg.sv
package cell_bal_gate_pkg;

  // Wrap any signed index into the range 0..modulus-1.
  function automatic int wrap_idx(input int value, input int modulus);
    return ((value % modulus) + modulus) % modulus;
  endfunction

  // Width needed to hold values 0..count-1.
  function automatic int idx_width(input int count);
    return (count > 1) ? $clog2(count) : 1;
  endfunction

endpackage

// File: rtl/cell_bal_period_decode.sv
module cell_bal_period_decode #(
  parameter int PAIR_COUNT = 6,
  parameter int PERIOD_W   = 4
) (
  input  logic [PERIOD_W-1:0]   period_i,
  output logic [PAIR_COUNT-1:0] pair_oh_o
);

  // One measurement slot and one calibration slot per pair.
  localparam int SLOT_COUNT = 2 * PAIR_COUNT;

  // Each pair position is active in its measurement slot and in the
  // calibration slot one half-sequence later. Values beyond the last
  // slot select no pair.
  for (genvar p = 0; p < PAIR_COUNT; p++) begin : g_pair
    localparam int MEAS_SLOT = p;
    localparam int CAL_SLOT  = p + PAIR_COUNT;
    logic meas_hit;
    logic cal_hit;
    assign meas_hit     = (period_i == PERIOD_W'(MEAS_SLOT));
    assign cal_hit      = (CAL_SLOT < SLOT_COUNT) && (period_i == PERIOD_W'(CAL_SLOT));
    assign pair_oh_o[p] = meas_hit | cal_hit;
  end

endmodule

// File: rtl/cell_bal_mask_gen.sv
module cell_bal_mask_gen
  import cell_bal_gate_pkg::*;
#(
  parameter int NUM_CELLS  = 12,
  parameter int PAIR_COUNT = 6,
  parameter int WIN_RADIUS = 1
) (
  input  logic [PAIR_COUNT-1:0] pair_oh_i,
  output logic [NUM_CELLS-1:0]  off_mask_o
);

  localparam int WIN_SPAN = 2 * WIN_RADIUS + 1;

  // A cell is masked when the active pair lies within WIN_RADIUS of its
  // own pair position, with wrap-around at the ends of the sequence.
  for (genvar c = 0; c < NUM_CELLS; c++) begin : g_cell
    localparam int HOME = c % PAIR_COUNT;
    logic [WIN_SPAN-1:0] tap_hit;
    for (genvar d = 0; d < WIN_SPAN; d++) begin : g_tap
      localparam int SRC = wrap_idx(HOME + d - WIN_RADIUS, PAIR_COUNT);
      assign tap_hit[d] = pair_oh_i[SRC];
    end
    assign off_mask_o[c] = |tap_hit;
  end

endmodule

// File: rtl/cell_bal_permit_track.sv
module cell_bal_permit_track (
  input  logic clk,
  input  logic rst_n,
  input  logic busy_i,
  input  logic permit_i,
  output logic permit_eff_o
);

  logic busy_q;
  logic permit_q;
  logic conv_start;
  logic permit_en;
  logic permit_d;

  // Next-state: capture the permit bit in the first busy cycle.
  always_comb begin
    conv_start   = busy_i & ~busy_q;
    permit_en    = conv_start;
    permit_d     = permit_i;
    permit_eff_o = conv_start ? permit_i : permit_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      permit_q <= 1'b0;
    end else begin
      busy_q <= busy_i;
      if (permit_en) begin
        permit_q <= permit_d;
      end
    end
  end

endmodule

// File: rtl/cell_bal_drive_reg.sv
module cell_bal_drive_reg #(
  parameter int NUM_CELLS = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 busy_i,
  input  logic                 permit_eff_i,
  input  logic [NUM_CELLS-1:0] req_i,
  input  logic [NUM_CELLS-1:0] off_mask_i,
  output logic [NUM_CELLS-1:0] drive_o
);

  logic                 gate_active;
  logic                 drive_en;
  logic [NUM_CELLS-1:0] drive_d;
  logic [NUM_CELLS-1:0] drive_q;

  always_comb begin
    gate_active = busy_i & ~permit_eff_i;
    drive_en    = 1'b1;
    drive_d     = gate_active ? (req_i & ~off_mask_i) : req_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drive_q <= '0;
    end else if (drive_en) begin
      drive_q <= drive_d;
    end
  end

  assign drive_o = drive_q;

endmodule

// File: rtl/cell_bal_gate.sv
module cell_bal_gate
  import cell_bal_gate_pkg::*;
#(
  parameter int NUM_CELLS  = 12,
  parameter int PAIR_COUNT = 6,
  parameter int PERIOD_W   = 4,
  parameter int WIN_RADIUS = 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_CELLS-1:0] dis_req_i,
  input  logic                 permit_i,
  input  logic                 busy_i,
  input  logic [PERIOD_W-1:0]  period_i,
  output logic [NUM_CELLS-1:0] dis_drive_o
);

  localparam int LANES      = NUM_CELLS / PAIR_COUNT;
  localparam int SLOT_COUNT = 2 * PAIR_COUNT;
  localparam int SLOT_W     = idx_width(SLOT_COUNT);

  logic [PAIR_COUNT-1:0] pair_oh;
  logic [NUM_CELLS-1:0]  off_mask;
  logic                  permit_eff;

  cell_bal_period_decode #(
    .PAIR_COUNT(PAIR_COUNT),
    .PERIOD_W  (PERIOD_W)
  ) decode_i (
    .period_i (period_i),
    .pair_oh_o(pair_oh)
  );

  cell_bal_mask_gen #(
    .NUM_CELLS (NUM_CELLS),
    .PAIR_COUNT(PAIR_COUNT),
    .WIN_RADIUS(WIN_RADIUS)
  ) mask_i (
    .pair_oh_i (pair_oh),
    .off_mask_o(off_mask)
  );

  cell_bal_permit_track permit_i_trk (
    .clk         (clk),
    .rst_n       (rst_n),
    .busy_i      (busy_i),
    .permit_i    (permit_i),
    .permit_eff_o(permit_eff)
  );

  cell_bal_drive_reg #(
    .NUM_CELLS(NUM_CELLS)
  ) drive_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .busy_i      (busy_i),
    .permit_eff_i(permit_eff),
    .req_i       (dis_req_i),
    .off_mask_i  (off_mask),
    .drive_o     (dis_drive_o)
  );

  initial begin
    assert (NUM_CELLS == LANES * PAIR_COUNT && SLOT_W <= PERIOD_W && 2 * WIN_RADIUS + 1 <= PAIR_COUNT)
      else $error("cell_bal_gate: inconsistent parameters");
  end

endmodule

// File: rtl/cell_bal_gate_chk.sv
module cell_bal_gate_chk #(
  parameter int NUM_CELLS  = 12,
  parameter int PAIR_COUNT = 6,
  parameter int PERIOD_W   = 4,
  parameter int WIN_RADIUS = 1
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NUM_CELLS-1:0] dis_req_i,
  input logic                 permit_i,
  input logic                 busy_i,
  input logic [PERIOD_W-1:0]  period_i,
  input logic [NUM_CELLS-1:0] dis_drive_o
);

  localparam int LANES      = NUM_CELLS / PAIR_COUNT;
  localparam int SLOT_COUNT = 2 * PAIR_COUNT;
  localparam int ON_COUNT   = NUM_CELLS - LANES * (2 * WIN_RADIUS + 1);

  // Observed permit, tracked from the ports.
  logic seen_busy;
  logic seen_permit;
  logic cur_permit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_busy   <= 1'b0;
      seen_permit <= 1'b0;
    end else begin
      seen_busy <= busy_i;
      if (busy_i && !seen_busy) seen_permit <= permit_i;
    end
  end

  assign cur_permit = seen_busy ? seen_permit : permit_i;

  AST_IDLE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_i |=> dis_drive_o == $past(dis_req_i)); // R2

  AST_PERMIT_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_i && cur_permit) |=> dis_drive_o == $past(dis_req_i)); // R3

  AST_WINDOW_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_i && !cur_permit && (int'(period_i) < SLOT_COUNT) && (&dis_req_i))
      |=> $countones(dis_drive_o) == ON_COUNT); // R7

  AST_OUT_OF_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_i && (int'(period_i) >= SLOT_COUNT)) |=> dis_drive_o == $past(dis_req_i)); // R10

  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (dis_drive_o & ~$past(dis_req_i)) == '0); // R11

  if (LANES > 1) begin : g_lane
    AST_LANE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      (dis_req_i[PAIR_COUNT-1:0] == dis_req_i[2*PAIR_COUNT-1:PAIR_COUNT])
        |=> dis_drive_o[PAIR_COUNT-1:0] == dis_drive_o[2*PAIR_COUNT-1:PAIR_COUNT]); // R6
  end

endmodule

bind cell_bal_gate cell_bal_gate_chk #(
  .NUM_CELLS (NUM_CELLS),
  .PAIR_COUNT(PAIR_COUNT),
  .PERIOD_W  (PERIOD_W),
  .WIN_RADIUS(WIN_RADIUS)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .dis_req_i  (dis_req_i),
  .permit_i   (permit_i),
  .busy_i     (busy_i),
  .period_i   (period_i),
  .dis_drive_o(dis_drive_o)
);

// File: tb/cell_bal_gate_tb_top.sv
`timescale 1ns/1ps
module cell_bal_gate_tb_top;

  logic        clk;
  logic        rst_n;
  logic [11:0] req;
  logic        permit;
  logic        busy;
  logic [3:0]  period;
  logic [11:0] drive;

  int checks;
  int fails;
  bit done;

  cell_bal_gate dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .dis_req_i  (req),
    .permit_i   (permit),
    .busy_i     (busy),
    .period_i   (period),
    .dis_drive_o(drive)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // {busy, permit, period, request, expected}
  localparam logic [29:0] VEC [14] = '{
    {1'b0, 1'b0, 4'd0,  12'hFFF, 12'hFFF}, // R2 idle
    {1'b1, 1'b0, 4'd0,  12'hFFF, 12'h71C}, // R4 pair 0 wraps to cells 6/12
    {1'b1, 1'b1, 4'd1,  12'hFFF, 12'hE38}, // R8 late permit ignored
    {1'b1, 1'b0, 4'd2,  12'hFFF, 12'hC71}, // R4
    {1'b1, 1'b0, 4'd3,  12'hFFF, 12'h8E3}, // R4
    {1'b1, 1'b0, 4'd4,  12'hFFF, 12'h1C7}, // R4
    {1'b1, 1'b0, 4'd5,  12'hFFF, 12'h38E}, // R4 pair 5 wraps to cells 1/7
    {1'b1, 1'b0, 4'd6,  12'hA5A, 12'h218}, // R5
    {1'b1, 1'b0, 4'd7,  12'h0F0, 12'h030}, // R5
    {1'b1, 1'b0, 4'd8,  12'h555, 12'h451}, // R5
    {1'b1, 1'b0, 4'd9,  12'h3C3, 12'h0C3}, // R5
    {1'b1, 1'b0, 4'd10, 12'hFFF, 12'h1C7}, // R5
    {1'b1, 1'b0, 4'd11, 12'h801, 12'h000}, // R5
    {1'b0, 1'b0, 4'd11, 12'h123, 12'h123}  // R2
  };

  function automatic logic [11:0] model_mask(input int per);
    logic [11:0] m;
    int p;
    m = '0;
    if (per < 12) begin
      p = per % 6;
      for (int n = 0; n < 12; n++) begin
        int k;
        k = n % 6;
        if (k == p || (k + 1) % 6 == p || (k + 5) % 6 == p) m[n] = 1'b1;
      end
    end
    return m;
  endfunction

  task automatic check(input string tag, input logic [11:0] act, input logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(input logic b, input logic pm, input logic [3:0] per, input logic [11:0] r);
    @(negedge clk);
    busy = b; permit = pm; period = per; req = r;
    @(posedge clk);
    #1;
  endtask

  initial begin
    checks = 0; fails = 0; done = 0;
    rst_n = 1'b0; req = 12'hFFF; permit = 1'b0; busy = 1'b0; period = 4'd0;
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset state", drive, 12'h000);
    @(negedge clk);
    rst_n = 1'b1;

    // Vector table walk
    for (int i = 0; i < 14; i++) begin
      step(VEC[i][29], VEC[i][28], VEC[i][27:24], VEC[i][23:12]);
      check($sformatf("R4/R5/R8 vector %0d", i), drive, VEC[i][11:0]);
    end

    // Permit set at start: no gating, later permit changes ignored
    step(1'b1, 1'b1, 4'd0, 12'hABC);
    check("R3 permitted period 0", drive, 12'hABC);
    for (int per = 1; per < 12; per++) begin
      step(1'b1, 1'b0, 4'(per), 12'hABC);
      check($sformatf("R3 R8 permitted period %0d", per), drive, 12'hABC);
    end
    step(1'b0, 1'b0, 4'd0, 12'h5A5);
    check("R2 idle after conversion", drive, 12'h5A5);

    // Unused period values
    step(1'b1, 1'b0, 4'd12, 12'hFFF);
    check("R10 period 12", drive, 12'hFFF);
    step(1'b1, 1'b0, 4'd15, 12'h3C3);
    check("R10 period 15", drive, 12'h3C3);
    step(1'b0, 1'b0, 4'd0, 12'h000);

    // Full sweep against model, lane equality and on-count
    for (int per = 0; per < 12; per++) begin
      step(1'b1, 1'b0, 4'(per), 12'hFFF);
      check($sformatf("R4 R5 sweep period %0d", per), drive, 12'hFFF & ~model_mask(per));
      check($sformatf("R6 lanes period %0d", per), {6'd0, drive[5:0]}, {6'd0, drive[11:6]});
      check($sformatf("R7 on-count period %0d", per), 12'($countones(drive)), 12'd6);
    end
    step(1'b0, 1'b0, 4'd0, 12'h000);

    // Permit recaptured on a new conversion (was 1 earlier, now 0)
    step(1'b1, 1'b0, 4'd0, 12'hFFF);
    check("R8 recapture permit 0", drive, 12'h71C);

    // Registered output: no change before the edge
    @(negedge clk);
    period = 4'd1;
    #1;
    check("R9 before edge", drive, 12'h71C);
    @(posedge clk);
    #1;
    check("R9 after edge", drive, 12'hE38);

    // Asynchronous reset mid-conversion
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1 async reset", drive, 12'h000);
    busy = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    step(1'b0, 1'b0, 4'd0, 12'h0F0);
    check("R2 idle after reset", drive, 12'h0F0);
    check("R11 no unrequested output", drive & ~12'h0F0, 12'h000);

    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog R1 actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule